// File: doc/BRIEF.md
# Segmented Address Translator

This block maps a 32-bit virtual address to a 30-bit physical address through a four-entry table. Each entry holds a physical base, a bound and a valid bit. In segmented operation the two most significant address bits pick the entry. The remaining 30 bits form an offset. That offset is compared against the entry's bound and added to its base. A request that names an empty entry, passes the bound, or lands past the top of the 30-bit physical space is reported as a fault instead of producing an address.

Software fills the table through a simple write port, one entry per cycle. Moving a segment elsewhere in physical memory only needs a new base for that entry. Programs keep using the same virtual offsets.

A run-time select input turns the block into a single-region relocation unit. In that mode entry 0 serves every request, and the whole 32-bit virtual address is the offset. Each result is registered and returned one cycle after its request.

Top module: `seg_xlate_top`

## Requirements
- R1: In segmented mode (`single_i` = 0), `req_va_i[31:30]` selects table entry 0..3 and `req_va_i[29:0]` is the offset.
- R2: For a request without a fault, `rsp_pa_o` equals the selected entry's base plus the offset.
- R3: An offset strictly greater than the selected entry's bound raises `rsp_err_o`. An offset equal to the bound is accepted.
- R4: A request that selects an entry whose valid bit is 0 raises `rsp_err_o`.
- R5: If base plus offset is 2^30 or more, `rsp_err_o` is raised.
- R6: Whenever `rsp_err_o` is 1, `rsp_pa_o` is zero.
- R7: `rsp_valid_o` equals `req_valid_i` from the previous clock edge. When `rsp_valid_o` is 0, both `rsp_err_o` and `rsp_pa_o` are 0.
- R8: A table write takes effect at the clock edge that samples it. A request sampled at that same edge still sees the old entry, and a request on the next cycle sees the new one.
- R9: Rewriting only an entry's base moves the physical result by the base difference. The bound check for the same offsets is unchanged.
- R10: With `single_i` = 1, entry 0 is used whatever the top bits are, and the offset is the full 32-bit virtual address.
- R11: Reset is asynchronous and active low. It clears all entries to invalid and drives `rsp_valid_o`, `rsp_err_o` and `rsp_pa_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 2 | Entry to write |
| wr_base_i | input | 30 | Physical base to store |
| wr_bound_i | input | 32 | Largest legal offset to store |
| wr_valid_i | input | 1 | Valid bit to store |
| single_i | input | 1 | 1: single-region relocation through entry 0 |
| req_valid_i | input | 1 | Translation request strobe |
| req_va_i | input | 32 | Virtual address |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_err_o | output | 1 | Fault on the returned request |
| rsp_pa_o | output | 30 | Physical address, zero on fault |

## Verification
A translation result appears on the outputs after the first rising edge that samples its request. The bench therefore drives each request on a falling edge and checks the outputs on the next falling edge. Requests in the vector table are issued back to back, so every check also confirms that neighbouring requests do not mix. A table write counts against requests one edge later. The bench issues a request in the same cycle as a write and expects the old entry, then issues one in the following cycle and expects the new one. Reset effects are checked while reset is still asserted, with no edge needed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned VA_W_DEF  = 32;
  localparam int unsigned PA_W_DEF  = 30;
  localparam int unsigned IDX_W_DEF = 2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUND   = 2'd2,
    FLT_RANGE   = 2'd3
  } fault_e;
endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned PA_W  = 30,
  parameter int unsigned BND_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [BND_W-1:0] wr_bound_i,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [BND_W-1:0] rd_bound_o,
  output logic             rd_valid_o
);
  localparam int unsigned N_ENT = 1 << IDX_W;

  logic [PA_W-1:0]  base_q  [N_ENT];
  logic [BND_W-1:0] bound_q [N_ENT];
  logic             vld_q   [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
        vld_q[g]   <= 1'b0;
      end else if (hit) begin
        base_q[g]  <= wr_base_i;
        bound_q[g] <= wr_bound_i;
        vld_q[g]   <= wr_valid_i;
      end
    end
  end

  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_bound_o = bound_q[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];

  // R8
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (base_q[$past(wr_idx_i)] == $past(wr_base_i)) &&
                (bound_q[$past(wr_idx_i)] == $past(wr_bound_i)) &&
                (vld_q[$past(wr_idx_i)] == $past(wr_valid_i)));
endmodule

// File: rtl/seg_xlate_split.sv
module seg_xlate_split #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             single_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [VA_W-1:0]  off_o
);
  localparam int unsigned SEG_OFF_W = VA_W - IDX_W;

  always_comb begin
    if (single_i) begin
      idx_o = '0;
      off_o = va_i;
    end else begin
      idx_o = va_i[VA_W-1 -: IDX_W];
      off_o = {{IDX_W{1'b0}}, va_i[SEG_OFF_W-1:0]};
    end
  end
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W  = 30,
  parameter int unsigned OFF_W = 32
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] bound_i,
  input  logic             ent_valid_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  pa_o,
  output fault_e           fault_o
);
  localparam int unsigned SUM_W = OFF_W + 1;

  logic [SUM_W-1:0] sum;
  logic             past_top;

  assign sum      = {{(SUM_W-PA_W){1'b0}}, base_i} + {1'b0, off_i};
  assign past_top = |sum[SUM_W-1:PA_W];
  assign pa_o     = sum[PA_W-1:0];

  // priority: missing entry, then bound, then physical range
  always_comb begin
    if (!ent_valid_i)           fault_o = FLT_INVALID;
    else if (off_i > bound_i)   fault_o = FLT_BOUND;
    else if (past_top)          fault_o = FLT_RANGE;
    else                        fault_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W  = VA_W_DEF,
  parameter int unsigned PA_W  = PA_W_DEF,
  parameter int unsigned IDX_W = IDX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [VA_W-1:0]  wr_bound_i,
  input  logic             wr_valid_i,
  input  logic             single_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [PA_W-1:0]  rsp_pa_o
);
  logic [IDX_W-1:0] sel_idx;
  logic [VA_W-1:0]  sel_off;
  logic [PA_W-1:0]  ent_base;
  logic [VA_W-1:0]  ent_bound;
  logic             ent_valid;
  logic [PA_W-1:0]  raw_pa;
  fault_e           fault;

  logic             vld_q;
  logic             err_q;
  logic [PA_W-1:0]  pa_q;

  seg_xlate_split #(.VA_W(VA_W), .IDX_W(IDX_W)) i_split (
    .va_i     (req_va_i),
    .single_i (single_i),
    .idx_o    (sel_idx),
    .off_o    (sel_off)
  );

  seg_xlate_table #(.IDX_W(IDX_W), .PA_W(PA_W), .BND_W(VA_W)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_base_i  (wr_base_i),
    .wr_bound_i (wr_bound_i),
    .wr_valid_i (wr_valid_i),
    .rd_idx_i   (sel_idx),
    .rd_base_o  (ent_base),
    .rd_bound_o (ent_bound),
    .rd_valid_o (ent_valid)
  );

  seg_xlate_check #(.PA_W(PA_W), .OFF_W(VA_W)) i_check (
    .base_i      (ent_base),
    .bound_i     (ent_bound),
    .ent_valid_i (ent_valid),
    .off_i       (sel_off),
    .pa_o        (raw_pa),
    .fault_o     (fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      pa_q  <= '0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i && fault == FLT_NONE) begin
        err_q <= 1'b0;
        pa_q  <= raw_pa;
      end else begin
        err_q <= req_valid_i;
        pa_q  <= '0;
      end
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_err_o   = err_q;
  assign rsp_pa_o    = pa_q;

  // R7
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_err_o && rsp_pa_o == '0));

  // R6
  pa_zero_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_pa_o == '0);

  // R3
  bound_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel_off > ent_bound) |=> rsp_err_o);

  // R4
  invalid_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ent_valid) |=> rsp_err_o);
endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_idx;
  logic [29:0] wr_base;
  logic [31:0] wr_bound;
  logic        wr_valid;
  logic        single;
  logic        req_valid;
  logic [31:0] req_va;
  logic        rsp_valid;
  logic        rsp_err;
  logic [29:0] rsp_pa;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  seg_xlate_top i_seg_xlate_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_base_i   (wr_base),
    .wr_bound_i  (wr_bound),
    .wr_valid_i  (wr_valid),
    .single_i    (single),
    .req_valid_i (req_valid),
    .req_va_i    (req_va),
    .rsp_valid_o (rsp_valid),
    .rsp_err_o   (rsp_err),
    .rsp_pa_o    (rsp_pa)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        single;
    logic [31:0] va;
    logic        err;
    logic [29:0] pa;
  } vec_t;

  // entries: 0 base 0x4000 bound 0x6ff; 1 base 0 bound 0x4ff;
  // 2 base 0x3fff_f000 bound 0x2000; 3 left invalid
  localparam int N_VEC = 11;
  localparam vec_t VECS [N_VEC] = '{
    '{4'd2,  1'b0, 32'h0000_0200, 1'b0, 30'h0000_4200}, // R2 seg0
    '{4'd3,  1'b0, 32'h0000_06ff, 1'b0, 30'h0000_46ff}, // R3 at bound
    '{4'd3,  1'b0, 32'h0000_0700, 1'b1, 30'h0},         // R3 past bound
    '{4'd1,  1'b0, 32'h4000_0100, 1'b0, 30'h0000_0100}, // R1 seg1
    '{4'd3,  1'b0, 32'h4000_0500, 1'b1, 30'h0},         // R3 seg1
    '{4'd5,  1'b0, 32'h8000_0fff, 1'b0, 30'h3fff_ffff}, // R5 top word
    '{4'd5,  1'b0, 32'h8000_1000, 1'b1, 30'h0},         // R5 past top
    '{4'd4,  1'b0, 32'hc000_0000, 1'b1, 30'h0},         // R4 invalid
    '{4'd10, 1'b1, 32'h0000_0600, 1'b0, 30'h0000_4600}, // R10 single
    '{4'd10, 1'b1, 32'h8000_0200, 1'b1, 30'h0},         // R10 full offset
    '{4'd1,  1'b0, 32'h8000_0200, 1'b0, 30'h3fff_f200}  // R1 same va segmented
  };

  task automatic check(input string tag, input logic v, input logic e,
                       input logic [29:0] pa);
    n_chk++;
    if (rsp_valid !== v || rsp_err !== e || rsp_pa !== pa) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b err=%0b pa=%h expected valid=%0b err=%0b pa=%h",
               tag, rsp_valid, rsp_err, rsp_pa, v, e, pa);
    end
  endtask

  task automatic tbl_write(input logic [1:0] idx, input logic [29:0] base,
                           input logic [31:0] bound, input logic v);
    wr_en = 1'b1; wr_idx = idx; wr_base = base; wr_bound = bound; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic s, input logic [31:0] va);
    req_valid = 1'b1; single = s; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_base = '0; wr_bound = '0;
    wr_valid = 1'b0; single = 1'b0; req_valid = 1'b0; req_va = '0;
    repeat (3) @(negedge clk);
    check("R11 outputs in reset", 1'b0, 1'b0, 30'h0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(1'b0, 32'h0000_0010);
    check("R11 entries invalid after reset", 1'b1, 1'b1, 30'h0);

    tbl_write(2'd0, 30'h0000_4000, 32'h0000_06ff, 1'b1);
    tbl_write(2'd1, 30'h0000_0000, 32'h0000_04ff, 1'b1);
    tbl_write(2'd2, 30'h3fff_f000, 32'h0000_2000, 1'b1);

    // back-to-back vectors
    for (int i = 0; i < N_VEC; i++) begin
      req_valid = 1'b1; single = VECS[i].single; req_va = VECS[i].va;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 1'b1, VECS[i].err, VECS[i].pa);
    end
    req_valid = 1'b0; req_va = 32'h0000_0200;
    @(negedge clk);
    check("R7 idle cycle", 1'b0, 1'b0, 30'h0);

    // R8: write and request in the same cycle
    wr_en = 1'b1; wr_idx = 2'd3; wr_base = 30'h0000_1000; wr_bound = 32'h0000_00ff;
    wr_valid = 1'b1;
    req_valid = 1'b1; single = 1'b0; req_va = 32'hc000_0010;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 same-cycle request sees old entry", 1'b1, 1'b1, 30'h0);
    @(negedge clk);
    check("R8 next-cycle request sees new entry", 1'b1, 1'b0, 30'h0000_1010);
    req_valid = 1'b0;

    // R9: relocate entry 1
    tbl_write(2'd1, 30'h0000_2000, 32'h0000_04ff, 1'b1);
    issue(1'b0, 32'h4000_0100);
    check("R9 relocated base", 1'b1, 1'b0, 30'h0000_2100);
    issue(1'b0, 32'h4000_0500);
    check("R9 bound kept", 1'b1, 1'b1, 30'h0);

    // R6 on an in-range fault after a good result
    issue(1'b0, 32'h4000_04ff);
    check("R6 good result before fault", 1'b1, 1'b0, 30'h0000_24ff);
    issue(1'b0, 32'h8000_1000);
    check("R6 fault zeroes address", 1'b1, 1'b1, 30'h0);

    // R11: asynchronous reset mid-run
    req_valid = 1'b1; single = 1'b0; req_va = 32'h0000_0100;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async clear", 1'b0, 1'b0, 30'h0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    issue(1'b0, 32'h0000_0100);
    check("R11 table cleared", 1'b1, 1'b1, 30'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule